// File: doc/BRIEF.md
# Best-Three-of-Eighteen Candidate Sorter

Nine trigger sources each offer up to two candidates per base clock cycle. Each candidate carries a quality grade and an enable bit. A source places its two candidates on its own backplane lane, one after the other, at twice the base rate. The sorter captures each pair, chooses the three strongest of the eighteen, and sends them onward on three output lanes. Each output lane runs at double rate and carries a winner as two half-words. Every source also receives, per candidate, a flag that says whether that candidate was chosen.

The block runs on the double-rate clock. A base cycle is two consecutive fast cycles. The phase counter restarts with reset and has value 0 in the first fast cycle after reset. A one-bit latch-phase input selects which fast cycle of the base cycle holds a source's first candidate. The delay from a pair's arrival to the return of its flags is a parameter (`WIN_LAT`, base cycles, default 8, minimum 2) and never varies. A source can therefore read the answer from a fixed slot of its own pipeline.

Top module: `bestThreeSorter`

## Requirements
- R1: While reset is high, and in the first fast cycle after it falls, `winFlags`, `laneHalf`, `laneValid` and `laneFirst` are all zero. A pair in flight when reset rises produces no result.
- R2: Fast cycles are numbered from 0 after reset. With `latchPhase` = p, the word on `srcWord[s]`/`srcValid[s]` in a cycle whose parity equals p is candidate 2s (first). The word in the following cycle is candidate 2s+1 (second). This holds for p = 0 and for p = 1.
- R3: Quality is bits [CW-1:CW-QW] of a word, and a higher value is stronger. Lane 0 carries the strongest valid candidate, lane 1 the next and lane 2 the third. A lane is never valid while a lower-numbered lane is invalid.
- R4: Among equal quality, the lower candidate index 2s+k (k = 0 for first) ranks stronger.
- R5: A candidate whose valid bit is 0 is never selected or flagged. When fewer than three candidates are valid, each unused lane has `laneValid` 0 and `laneHalf` all zero.
- R6: Let t be the cycle in which a pair's second word is on the bus. In cycle t+3 each lane shows bits [HALF-1:0] of its winner with `laneFirst` = 1. In cycle t+4 it shows bits [CW-1:HALF] with `laneFirst` = 0. `laneValid` holds the same value in both cycles.
- R7: `winFlags` bit 2s+k is 1 exactly when candidate 2s+k was selected. The flags appear in cycle t+2·WIN_LAT and stay unchanged through cycle t+2·WIN_LAT+1.
- R8: At most three bits of `winFlags` are set, and the number set equals the number of valid lanes for the same pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| latchPhase | input | 1 | Fast-cycle parity that carries a source's first candidate |
| srcWord | input | NSRC×CW | Per-source backplane word, two per base cycle |
| srcValid | input | NSRC | Per-source candidate valid, sampled with the word |
| winFlags | output | 2·NSRC | Selected flag per candidate, index 2s+k |
| laneHalf | output | NWIN×CW/2 | Per-lane half-word of the winner |
| laneValid | output | NWIN | Per-lane winner valid |
| laneFirst | output | 1 | High when lanes carry the low half |

## Verification
The properties assume that `latchPhase` only changes while reset is high. They also assume each source presents its two words in the fast-cycle order that the phase count fixes from reset release. Under these conditions the half-word alternation, the hold of lane validity, and the pairing of flag updates with `laneFirst` are all stable. The stimulus changes the latch phase only inside a reset. It drives every pair on the parity that the current setting selects, and it keeps the enables low outside those pairs. As a result, every captured pair is a complete, deliberate pair.

// File: rtl/bestSortPkg.sv
package bestSortPkg;

  // Strobes handed from the phase controller to the datapath
  typedef struct packed {
    logic takeFirst;  // capture the first candidate of each source
    logic takePair;   // complete the pair and present it to the sorter
    logic sendLow;    // serialiser emits the low half of each winner
  } sortStrobe_t;

endpackage

// File: rtl/sortCtl.sv
module sortCtl
  import bestSortPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        latchPhase,
  output sortStrobe_t strobe
);

  logic slot;

  always_ff @(posedge clk) begin
    if (rst) slot <= 1'b0;
    else     slot <= ~slot;
  end

  always_comb begin
    strobe.takeFirst = (slot == latchPhase);
    strobe.takePair  = (slot != latchPhase);
    strobe.sendLow   = (slot != latchPhase);
  end

endmodule

// File: rtl/rankSorter.sv
module rankSorter #(
  parameter int NCAND = 18,
  parameter int CW    = 16,
  parameter int QW    = 4,
  parameter int NWIN  = 3
) (
  input  logic [NCAND-1:0][CW-1:0] cand,
  input  logic [NCAND-1:0]         candValid,
  output logic [NWIN-1:0][CW-1:0]  winWord,
  output logic [NWIN-1:0]          winValid,
  output logic [NCAND-1:0]         selMask
);

  localparam int RW = $clog2(NCAND) + 1;
  localparam logic [RW-1:0] NWIN_R = RW'(NWIN);

  logic [RW-1:0] rank [NCAND];

  // Each candidate counts how many valid rivals outrank it; ties go to
  // the lower index, so valid candidates get distinct ranks.
  always_comb begin
    for (int i = 0; i < NCAND; i++) begin
      rank[i] = '0;
      for (int j = 0; j < NCAND; j++) begin
        if (j != i && candValid[j]) begin
          if ((cand[j][CW-1 -: QW] > cand[i][CW-1 -: QW]) ||
              ((cand[j][CW-1 -: QW] == cand[i][CW-1 -: QW]) && (j < i)))
            rank[i] = rank[i] + RW'(1);
        end
      end
      selMask[i] = candValid[i] && (rank[i] < NWIN_R);
    end
    for (int r = 0; r < NWIN; r++) begin
      winWord[r]  = '0;
      winValid[r] = 1'b0;
      for (int i = 0; i < NCAND; i++) begin
        if (selMask[i] && (rank[i] == RW'(r))) begin
          winWord[r]  = cand[i];
          winValid[r] = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sortDatapath.sv
module sortDatapath
  import bestSortPkg::*;
#(
  parameter int NSRC    = 9,
  parameter int CW      = 16,
  parameter int QW      = 4,
  parameter int NWIN    = 3,
  parameter int WIN_LAT = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  sortStrobe_t                strobe,
  input  logic [NSRC-1:0][CW-1:0]    srcWord,
  input  logic [NSRC-1:0]            srcValid,
  output logic [2*NSRC-1:0]          winFlags,
  output logic [NWIN-1:0][CW/2-1:0]  laneHalf,
  output logic [NWIN-1:0]            laneValid,
  output logic                       laneFirst
);

  localparam int NCAND    = 2 * NSRC;
  localparam int HALF     = CW / 2;
  // The pair register and the sort register use two of the fast cycles
  localparam int FLAG_DLY = 2 * WIN_LAT - 2;

  logic [NSRC-1:0][CW-1:0]  holdWord;
  logic [NSRC-1:0]          holdValid;
  logic [NCAND-1:0][CW-1:0] pairWord;
  logic [NCAND-1:0]         pairValid;

  logic [NWIN-1:0][CW-1:0]  nextWin;
  logic [NWIN-1:0]          nextWinValid;
  logic [NCAND-1:0]         nextMask;

  logic [NWIN-1:0][CW-1:0]  sortWord;
  logic [NWIN-1:0]          sortValid;
  logic [NCAND-1:0]         sortMask;

  // Demultiplex the double-rate words into candidate pairs
  always_ff @(posedge clk) begin
    if (rst) begin
      holdWord  <= '0;
      holdValid <= '0;
      pairWord  <= '0;
      pairValid <= '0;
    end else begin
      for (int s = 0; s < NSRC; s++) begin
        if (strobe.takeFirst) begin
          holdWord[s]  <= srcWord[s];
          holdValid[s] <= srcValid[s];
        end
        if (strobe.takePair) begin
          pairWord[2*s]    <= holdWord[s];
          pairValid[2*s]   <= holdValid[s];
          pairWord[2*s+1]  <= srcWord[s];
          pairValid[2*s+1] <= srcValid[s];
        end
      end
    end
  end

  rankSorter #(
    .NCAND(NCAND), .CW(CW), .QW(QW), .NWIN(NWIN)
  ) u_rank (
    .cand(pairWord),
    .candValid(pairValid),
    .winWord(nextWin),
    .winValid(nextWinValid),
    .selMask(nextMask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sortWord  <= '0;
      sortValid <= '0;
      sortMask  <= '0;
    end else begin
      sortWord  <= nextWin;
      sortValid <= nextWinValid;
      sortMask  <= nextMask;
    end
  end

  // Fixed-length flag return path
  generate
    if (FLAG_DLY == 0) begin : g_flagDirect
      assign winFlags = sortMask;
    end else begin : g_flagPipe
      logic [FLAG_DLY-1:0][NCAND-1:0] flagPipe;
      always_ff @(posedge clk) begin
        if (rst) begin
          flagPipe <= '0;
        end else begin
          flagPipe[0] <= sortMask;
          for (int k = 1; k < FLAG_DLY; k++) flagPipe[k] <= flagPipe[k-1];
        end
      end
      assign winFlags = flagPipe[FLAG_DLY-1];
    end
  endgenerate

  // Output serialiser: low half then high half of each winner
  always_ff @(posedge clk) begin
    if (rst) begin
      laneHalf  <= '0;
      laneValid <= '0;
      laneFirst <= 1'b0;
    end else begin
      for (int r = 0; r < NWIN; r++) begin
        laneHalf[r] <= strobe.sendLow ? sortWord[r][HALF-1:0]
                                      : sortWord[r][CW-1:HALF];
      end
      laneValid <= sortValid;
      laneFirst <= strobe.sendLow;
    end
  end

endmodule

// File: rtl/bestThreeSorter.sv
module bestThreeSorter
  import bestSortPkg::*;
#(
  parameter int NSRC    = 9,
  parameter int CW      = 16,
  parameter int QW      = 4,
  parameter int NWIN    = 3,
  parameter int WIN_LAT = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      latchPhase,
  input  logic [NSRC-1:0][CW-1:0]   srcWord,
  input  logic [NSRC-1:0]           srcValid,
  output logic [2*NSRC-1:0]         winFlags,
  output logic [NWIN-1:0][CW/2-1:0] laneHalf,
  output logic [NWIN-1:0]           laneValid,
  output logic                      laneFirst
);

  sortStrobe_t strobe;

  sortCtl u_ctl (
    .clk(clk),
    .rst(rst),
    .latchPhase(latchPhase),
    .strobe(strobe)
  );

  sortDatapath #(
    .NSRC(NSRC), .CW(CW), .QW(QW), .NWIN(NWIN), .WIN_LAT(WIN_LAT)
  ) u_dp (
    .clk(clk),
    .rst(rst),
    .strobe(strobe),
    .srcWord(srcWord),
    .srcValid(srcValid),
    .winFlags(winFlags),
    .laneHalf(laneHalf),
    .laneValid(laneValid),
    .laneFirst(laneFirst)
  );

endmodule

// File: rtl/bestThreeSorter_chk.sv
module bestThreeSorter_chk #(
  parameter int NSRC = 9,
  parameter int CW   = 16,
  parameter int QW   = 4,
  parameter int NWIN = 3
) (
  input logic                      clk,
  input logic                      rst,
  input logic [2*NSRC-1:0]         winFlags,
  input logic [NWIN-1:0][CW/2-1:0] laneHalf,
  input logic [NWIN-1:0]           laneValid,
  input logic                      laneFirst
);

  localparam int HALF = CW / 2;

  assert_flag_limit_R8: assert property (@(posedge clk) disable iff (rst)
    $countones(winFlags) <= NWIN);

  assert_flag_hold_R7: assert property (@(posedge clk) disable iff (rst)
    laneFirst |-> $stable(winFlags));

  assert_half_alternate_R6: assert property (@(posedge clk) disable iff (rst)
    laneFirst |=> !laneFirst);

  assert_valid_hold_R6: assert property (@(posedge clk) disable iff (rst)
    laneFirst |=> $stable(laneValid));

  assert_quality_order_R3: assert property (@(posedge clk) disable iff (rst)
    (!laneFirst && laneValid[1]) |->
      (laneHalf[0][HALF-1 -: QW] >= laneHalf[1][HALF-1 -: QW]));

  generate
    for (genvar r = 1; r < NWIN; r++) begin : g_order
      assert_lane_order_R3: assert property (@(posedge clk) disable iff (rst)
        laneValid[r] |-> laneValid[r-1]);
    end
    for (genvar r = 0; r < NWIN; r++) begin : g_empty
      assert_empty_lane_R5: assert property (@(posedge clk) disable iff (rst)
        !laneValid[r] |-> (laneHalf[r] == '0));
    end
  endgenerate

endmodule

bind bestThreeSorter bestThreeSorter_chk #(
  .NSRC(NSRC), .CW(CW), .QW(QW), .NWIN(NWIN)
) u_chk (
  .clk(clk),
  .rst(rst),
  .winFlags(winFlags),
  .laneHalf(laneHalf),
  .laneValid(laneValid),
  .laneFirst(laneFirst)
);

// File: tb/bestThreeSorter_bench.sv
module bestThreeSorter_bench;

  localparam int NSRC    = 9;
  localparam int NCAND   = 2 * NSRC;
  localparam int CW      = 16;
  localparam int QW      = 4;
  localparam int NWIN    = 3;
  localparam int WIN_LAT = 8;
  localparam int HALF    = CW / 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                      rst;
  logic                      latchPhase;
  logic [NSRC-1:0][CW-1:0]   srcWord;
  logic [NSRC-1:0]           srcValid;
  logic [NCAND-1:0]          winFlags;
  logic [NWIN-1:0][HALF-1:0] laneHalf;
  logic [NWIN-1:0]           laneValid;
  logic                      laneFirst;

  bestThreeSorter #(
    .NSRC(NSRC), .CW(CW), .QW(QW), .NWIN(NWIN), .WIN_LAT(WIN_LAT)
  ) u_bestThreeSorter (
    .clk(clk), .rst(rst), .latchPhase(latchPhase),
    .srcWord(srcWord), .srcValid(srcValid),
    .winFlags(winFlags), .laneHalf(laneHalf),
    .laneValid(laneValid), .laneFirst(laneFirst)
  );

  int    cyc, compared, mismatched, framesLeft, mode;
  bit    pending, done;
  string sect;

  logic [CW-1:0] fw [NCAND];
  logic          fv [NCAND];

  // Expected results keyed by the cycle of a pair's second word
  logic [NCAND-1:0]     expFlags [int];
  logic [NWIN*CW-1:0]   expWin   [int];
  logic [NWIN-1:0]      expVal   [int];

  task automatic note(input bit bad, input string req, input string what,
                      input logic [63:0] got, input logic [63:0] exp);
    compared++;
    if (bad) begin
      mismatched++;
      $display("FAIL %s [%s] %s cycle %0d: got %h expected %h",
               req, sect, what, cyc, got, exp);
    end
  endtask

  function automatic void genFrame();
    for (int i = 0; i < NCAND; i++) begin
      fw[i] = CW'($urandom);
      fv[i] = 1'b0;
      case (mode)
        0: fv[i] = ($urandom % 4) != 0;
        1: begin fv[i] = ($urandom % 3) != 0; fw[i][CW-1 -: QW] = 4'd9; end
        4: begin fv[i] = 1'b1; fw[i][CW-1 -: QW] = QW'($urandom % 3); end
        default: fv[i] = 1'b0;
      endcase
    end
    if (mode == 2) begin
      for (int k = 0; k < int'($urandom % 3); k++) fv[$urandom % NCAND] = 1'b1;
    end
  endfunction

  // Behavioural pick: repeatedly take the strongest remaining, scanning
  // upwards so that equal quality keeps the lower index
  function automatic void computeExpect(input int t);
    logic [NCAND-1:0]   m = '0;
    logic [NWIN*CW-1:0] w = '0;
    logic [NWIN-1:0]    v = '0;
    for (int r = 0; r < NWIN; r++) begin
      int best = -1;
      for (int i = 0; i < NCAND; i++) begin
        if (fv[i] && !m[i]) begin
          if (best < 0) best = i;
          else if (fw[i][CW-1 -: QW] > fw[best][CW-1 -: QW]) best = i;
        end
      end
      if (best >= 0) begin
        m[best] = 1'b1;
        w[r*CW +: CW] = fw[best];
        v[r] = 1'b1;
      end
    end
    expFlags[t] = m;
    expWin[t]   = w;
    expVal[t]   = v;
  endfunction

  task automatic driveAndCheck();
    int p = int'(latchPhase);
    logic [NCAND-1:0]          eF;
    logic [NWIN-1:0][HALF-1:0] eH;
    logic [NWIN-1:0]           eV;
    logic                      eFirst;
    srcWord  = '0;
    srcValid = '0;
    if (((cyc & 1) == p) && framesLeft > 0) begin
      genFrame();
      for (int s = 0; s < NSRC; s++) begin
        srcWord[s] = fw[2*s]; srcValid[s] = fv[2*s];
      end
      pending = 1'b1;
      framesLeft--;
    end else if (pending && ((cyc & 1) != p)) begin
      for (int s = 0; s < NSRC; s++) begin
        srcWord[s] = fw[2*s+1]; srcValid[s] = fv[2*s+1];
      end
      computeExpect(cyc);
      pending = 1'b0;
    end

    // R7/R8: flags two cycles wide, WIN_LAT base cycles after the pair
    eF = '0;
    if (expFlags.exists(cyc - 2*WIN_LAT))          eF = expFlags[cyc - 2*WIN_LAT];
    else if (expFlags.exists(cyc - 2*WIN_LAT - 1)) eF = expFlags[cyc - 2*WIN_LAT - 1];
    // R3/R5/R6: low half three cycles after the pair, high half one later
    eH = '0;
    eV = '0;
    for (int r = 0; r < NWIN; r++) begin
      if (expWin.exists(cyc - 3)) begin
        eH[r] = expWin[cyc - 3][r*CW +: HALF];
        eV[r] = expVal[cyc - 3][r];
      end else if (expWin.exists(cyc - 4)) begin
        eH[r] = expWin[cyc - 4][r*CW + HALF +: HALF];
        eV[r] = expVal[cyc - 4][r];
      end
    end
    eFirst = (cyc == 0) ? 1'b0 : (((cyc - 1) & 1) != p);

    note(winFlags !== eF, (cyc == 0) ? "R1" : "R7", "winFlags", 64'(winFlags), 64'(eF));
    note({laneValid, laneHalf} !== {eV, eH}, (cyc == 0) ? "R1" : "R3", "lanes",
         64'({laneValid, laneHalf}), 64'({eV, eH}));
    note(laneFirst !== eFirst, (cyc == 0) ? "R1" : "R6", "laneFirst",
         64'(laneFirst), 64'(eFirst));
  endtask

  task automatic step();
    driveAndCheck();
    @(posedge clk);
    cyc++;
    @(negedge clk);
  endtask

  task automatic doReset(input logic p);
    rst        = 1'b1;
    latchPhase = p;
    framesLeft = 0;
    pending    = 1'b0;
    srcWord    = '0;
    srcValid   = '0;
    expFlags.delete();
    expWin.delete();
    expVal.delete();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cyc = 0;
  endtask

  task automatic runFrames(input int n, input int m, input string s);
    sect       = s;
    mode       = m;
    framesLeft = n;
    while (framesLeft > 0 || pending) step();
  endtask

  task automatic drain();
    repeat (2*WIN_LAT + 6) step();
  endtask

  initial begin
    compared = 0; mismatched = 0; done = 1'b0; sect = "R1";
    doReset(1'b0);
    sect = "R1";
    repeat (4) step();                 // R1 reset state
    runFrames(24, 0, "R3");            // mixed qualities and enables
    runFrames(12, 1, "R4");            // equal quality, index decides
    runFrames(12, 2, "R5");            // fewer than three valid
    runFrames(4,  3, "R5");            // nothing valid
    runFrames(12, 4, "R4");            // all valid, heavy ties
    drain();

    // R1: reset while pairs are in flight leaves nothing behind
    sect = "R1"; mode = 0; framesLeft = 4;
    repeat (7) step();
    doReset(1'b0);
    drain();

    // R2: opposite latch phase
    doReset(1'b1);
    runFrames(16, 0, "R2");
    runFrames(8,  1, "R2");
    runFrames(6,  2, "R2");
    drain();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule